// File: doc/BRIEF.md
# Synchronous Serial Receiver

This block is the receive half of a clocked serial port. Serial data arrives one bit per rising edge of a serial clock, most significant bit first. Eight bits make one frame. In slave mode the clock comes in on a pin, and bits count only while an active-low select input is held low. In master mode the block makes the clock itself from the system clock through a programmable divider. It runs that clock only for the eight bit times of one frame. All serial pins pass through a two-stage synchroniser into the system clock domain.

Software uses a small register port to enable reception and to arm it with a dummy read of the data register. It then collects each completed frame from that same register. A full flag and an optional level interrupt mark stored data. The block also watches how a read of the data register lines up with the frame that follows the stored one:
- If the read lands while that next frame is still arriving, the block sets a sticky conflict flag and does not store the frame.
- If the register is never read during that frame, the new byte is discarded and no flag changes.

Top module: `sync_serial_rx`

Register map (2-bit address):

| Address | Register | Bits |
|---|---|---|
| 0 | control | bit0 receive enable, bit1 interrupt enable, bit2 master mode |
| 1 | divider | clock divider value |
| 2 | status | bit0 full, bit1 conflict |
| 3 | data | read-only received byte |

## Requirements
- R1: After reset, every register reads 0, and the `irq` and `sclkOut` outputs are 0.
- R2: Frames are not captured until two things have happened, in order: a write sets receive enable (address 0, bit0), and then address 3 is read. Before that, serial traffic leaves the status at 0.
- R3: In slave mode, a bit is taken on each rising edge of `sclkIn` while `selN` is low, MSB first, eight bits per frame. Clock edges while `selN` is high are ignored. Raising `selN` throws away any partial frame.
- R4: A frame is stored when it completes, if it began with the full flag clear and the conflict flag clear. Storing puts the byte at address 3 and sets the full flag (address 2, bit0).
- R5: `irq` is high exactly while the full flag is 1 and interrupt enable (address 0, bit1) is 1.
- R6: A read of address 3 clears the full flag. If a frame is stored in that same cycle, the flag ends up set.
- R7: Suppose a frame begins while the full flag is 1, and address 3 is read while that frame is in progress. A frame is in progress from the cycle of its first bit through the cycle of its last bit, both included. Then, when the frame completes, the conflict flag (address 2, bit1) is set and the frame is not stored.
- R8: Suppose a frame begins while the full flag is 1, and address 3 is not read before it completes. Then the frame is discarded: the data and both flags stay unchanged.
- R9: The conflict flag stays set until a write to address 2 with bit1 = 0. While it is set, completed frames are not stored.
- R10: In master mode (address 0, bit2), a frame starts when reception is armed, no frame is running and the full flag is clear. Each `sclkOut` level lasts divider+1 system clocks, with the divider at address 1. Each frame gives exactly eight rising edges, sampled on `sdIn`. `sclkOut` is low when idle and always low in slave mode.
- R11: Clearing receive enable abandons any partial frame, resets the bit count and disarms reception. The stored byte and both flags are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects apply at address 3) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| sclkIn | input | 1 | Serial clock from a remote master |
| selN | input | 1 | Active-low slave select |
| sdIn | input | 1 | Serial data |
| sclkOut | output | 1 | Serial clock produced in master mode |
| irq | output | 1 | Receive interrupt |

## Verification
The interesting collisions are a data register read and a frame boundary landing on the same clock edge. The bench times its read so that it reaches the first bit of a frame that started while the register was full. It also times a read to reach the last bit of such a frame, and to reach the last bit of a frame that started with the register empty. The first two must raise the conflict flag. The third must store the byte, with the store winning over the clear of the full flag. A behavioural model, fed the same pin and register traffic, predicts the flags, the interrupt and the stored byte for every cycle. Fixed expected constants back up the model at each of these points.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxActive;     // enabled and armed
    logic startMaster;  // launch one master-mode frame
    logic storeFrame;   // capture the completing frame
  } rxStrobes_t;
endpackage

// File: rtl/ssrx_datapath.sv
module ssrx_datapath
  import ssrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic              masterMode,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              sclkIn,
  input  logic              selN,
  input  logic              sdIn,
  output logic              sclkOut,
  output logic              bitFirst,
  output logic              frameDone,
  output logic              masterBusy,
  output logic [DATA_W-1:0] rxData
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  // Input synchronisers (SYNC_STAGES >= 2)
  logic [SYNC_STAGES-1:0] sclkPipe, selPipe, sdPipe;
  logic sclkPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      selPipe  <= '1;
      sdPipe   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      selPipe  <= {selPipe[SYNC_STAGES-2:0], selN};
      sdPipe   <= {sdPipe[SYNC_STAGES-2:0], sdIn};
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  logic sclkSync, selSync, sdSync;
  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign selSync  = selPipe[SYNC_STAGES-1];
  assign sdSync   = sdPipe[SYNC_STAGES-1];

  // Master clock generator
  logic             mRun, mLevel, mLast;
  logic [DIV_W-1:0] mCnt;
  logic             mTurn, masterEdge, slaveEdge, bitTick;
  assign mTurn      = mRun && (mCnt == divVal);
  assign masterEdge = mTurn && !mLevel;
  assign slaveEdge  = sclkSync && !sclkPrev && !selSync;
  assign bitTick    = strobes.rxActive && (masterMode ? masterEdge : slaveEdge);

  // Bit counter and shift register
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg, shiftNext;
  logic              lastBit;
  assign lastBit   = (bitCnt == LAST_BIT);
  assign shiftNext = {shiftReg[DATA_W-2:0], sdSync};
  assign bitFirst  = bitTick && (bitCnt == '0);
  assign frameDone = bitTick && lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (!strobes.rxActive || (!masterMode && selSync)) begin
      bitCnt <= '0;
    end else if (bitTick) begin
      shiftReg <= shiftNext;
      bitCnt   <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxData <= '0;
    else if (strobes.storeFrame) rxData <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRun   <= 1'b0;
      mLevel <= 1'b0;
      mLast  <= 1'b0;
      mCnt   <= '0;
    end else if (!strobes.rxActive || !masterMode) begin
      mRun   <= 1'b0;
      mLevel <= 1'b0;
      mLast  <= 1'b0;
      mCnt   <= '0;
    end else if (strobes.startMaster) begin
      mRun   <= 1'b1;
      mLevel <= 1'b0;
      mLast  <= 1'b0;
      mCnt   <= '0;
    end else if (mRun) begin
      if (frameDone) mLast <= 1'b1;
      if (mTurn) begin
        mCnt   <= '0;
        mLevel <= !mLevel;
        if (mLevel && mLast) mRun <= 1'b0;
      end else begin
        mCnt <= mCnt + 1'b1;
      end
    end
  end

  assign sclkOut    = mLevel;
  assign masterBusy = mRun;

  // R4: control only stores on a completing bit
  a_r4_store_on_done: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeFrame |-> frameDone);
  // R11: losing enable/arming empties the counter and parks the clock
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rxActive |=> (bitCnt == '0 && !sclkOut));
  // R10: a master frame ends with the clock low
  a_r10_stop_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mRun) |-> !mLevel);
endmodule

// File: rtl/ssrx_control.sv
module ssrx_control
  import ssrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic              bitFirst,
  input  logic              frameDone,
  input  logic              masterBusy,
  output rxStrobes_t        strobes,
  output logic              masterMode,
  output logic [DIV_W-1:0]  divVal,
  output logic              irq
);
  logic rxEn, irqEn, full, conflict, armed, startedFull, readSeen;
  logic readData, wrCtrl, wrDiv, wrStat, storeNow, conflictNow;

  assign readData = regRdEn && (regAddr == ADDR_DATA);
  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrDiv    = regWrEn && (regAddr == ADDR_DIV);
  assign wrStat   = regWrEn && (regAddr == ADDR_STAT);

  assign storeNow    = frameDone && !conflict && !startedFull;
  assign conflictNow = frameDone && !conflict && startedFull && (readSeen || readData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn        <= 1'b0;
      irqEn       <= 1'b0;
      masterMode  <= 1'b0;
      divVal      <= '0;
      full        <= 1'b0;
      conflict    <= 1'b0;
      armed       <= 1'b0;
      startedFull <= 1'b0;
      readSeen    <= 1'b0;
    end else begin
      if (wrCtrl) {masterMode, irqEn, rxEn} <= regWrData[2:0];
      if (wrDiv) divVal <= regWrData[DIV_W-1:0];
      armed <= rxEn && (armed || readData);
      if (storeNow) full <= 1'b1;
      else if (readData) full <= 1'b0;
      if (conflictNow) conflict <= 1'b1;
      else if (wrStat && !regWrData[1]) conflict <= 1'b0;
      if (bitFirst) begin
        startedFull <= full;
        readSeen    <= readData;
      end else begin
        readSeen <= readSeen || readData;
      end
    end
  end

  assign strobes.rxActive    = rxEn && armed;
  assign strobes.startMaster = rxEn && armed && masterMode && !masterBusy && !full;
  assign strobes.storeFrame  = storeNow;
  assign irq = full && irqEn;

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = REG_W'({masterMode, irqEn, rxEn});
      ADDR_DIV:  regRdData = REG_W'(divVal);
      ADDR_STAT: regRdData = REG_W'({conflict, full});
      default:   regRdData = REG_W'(rxData);
    endcase
  end

  // R6: a read with no completing frame leaves the register empty
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readData && !frameDone) |=> !full);
  // R9: conflict persists until written with bit1 low
  a_r9_conflict_holds: assert property (@(posedge clk) disable iff (!rstN)
    (conflict && !(wrStat && !regWrData[1])) |=> conflict);
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import ssrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclkIn,
  input  logic       selN,
  input  logic       sdIn,
  output logic       sclkOut,
  output logic       irq
);
  rxStrobes_t        strobes;
  logic              masterMode, bitFirst, frameDone, masterBusy;
  logic [DIV_W-1:0]  divVal;
  logic [DATA_W-1:0] rxData;

  ssrx_control #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxData(rxData), .bitFirst(bitFirst), .frameDone(frameDone),
    .masterBusy(masterBusy), .strobes(strobes), .masterMode(masterMode),
    .divVal(divVal), .irq(irq)
  );

  ssrx_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .masterMode(masterMode),
    .divVal(divVal), .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn),
    .sclkOut(sclkOut), .bitFirst(bitFirst), .frameDone(frameDone),
    .masterBusy(masterBusy), .rxData(rxData)
  );
endmodule

// File: tb/sim_sync_serial_rx.sv
module sim_sync_serial_rx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sclkIn = 1'b0, selN = 1'b1, sdIn = 1'b0;
  logic       sclkOut, irq;

  int nChk = 0, nFail = 0;
  bit cmpOn = 1'b1;
  bit done = 1'b0;

  always #4 clk = !clk;

  sync_serial_rx u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn), .sclkOut(sclkOut), .irq(irq)
  );

  // Behavioural reference, slave mode
  bit       mFull, mConf, mArmed, mRxEn, mIrqEn, mMaster, mSF, mRS;
  bit [7:0] mData, mShift, mDiv;
  int       mCnt;
  bit       h1Sclk, h2Sclk, h3Sclk, h1Sel, h2Sel, h1Sd, h2Sd;

  always @(posedge clk or negedge rstN) begin
    bit rd, tick, store, setConf, act;
    if (!rstN) begin
      mFull = 0; mConf = 0; mArmed = 0; mRxEn = 0; mIrqEn = 0; mMaster = 0;
      mSF = 0; mRS = 0; mData = 0; mShift = 0; mDiv = 0; mCnt = 0;
      h1Sclk = 0; h2Sclk = 0; h3Sclk = 0; h1Sel = 1; h2Sel = 1; h1Sd = 0; h2Sd = 0;
    end else begin
      rd = regRdEn && regAddr == 2'd3;
      act = mRxEn && mArmed;
      tick = 0; store = 0; setConf = 0;
      if (!act) mCnt = 0;
      else if (!mMaster) begin
        if (h2Sel) mCnt = 0;
        else if (h2Sclk && !h3Sclk) tick = 1;
      end
      if (tick && mCnt == 0) begin mSF = mFull; mRS = rd; end
      else mRS = mRS | rd;
      if (tick) begin
        mShift = {mShift[6:0], h2Sd};
        mCnt++;
        if (mCnt == 8) begin
          mCnt = 0;
          if (!mConf && mSF && mRS) setConf = 1;
          if (!mConf && !mSF) begin store = 1; mData = mShift; end
        end
      end
      if (store) mFull = 1; else if (rd) mFull = 0;
      if (setConf) mConf = 1;
      else if (regWrEn && regAddr == 2'd2 && !regWrData[1]) mConf = 0;
      mArmed = mRxEn && (mArmed || rd);
      if (regWrEn && regAddr == 2'd0) {mMaster, mIrqEn, mRxEn} = regWrData[2:0];
      if (regWrEn && regAddr == 2'd1) mDiv = regWrData;
      h3Sclk = h2Sclk; h2Sclk = h1Sclk; h1Sclk = sclkIn;
      h2Sel = h1Sel; h1Sel = selN;
      h2Sd = h1Sd; h1Sd = sdIn;
    end
  end

  function automatic int expReg(int a);
    case (a)
      0: return int'({mMaster, mIrqEn, mRxEn});
      1: return int'(mDiv);
      2: return int'({mConf, mFull});
      default: return int'(mData);
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cmpOn && !done) begin
      check("R5 irq", int'(irq), int'(mFull && mIrqEn));
      check("R10 sclkOut idle in slave", int'(sclkOut), 0);
    end
  end

  task automatic wrReg(int a, int d);
    @(negedge clk);
    regWrEn = 1; regRdEn = 0; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 0;
  endtask

  // exp < 0: use the model; otherwise also compare with the model
  task automatic rdChk(int a, int exp, string tag);
    @(negedge clk);
    regRdEn = 1; regWrEn = 0; regAddr = 2'(a);
    #1;
    if (exp >= 0) check(tag, int'(regRdData), exp);
    if (cmpOn) check(tag, int'(regRdData), expReg(a));
    @(negedge clk);
    regRdEn = 0;
  endtask

  // Slave frame: 4 cycles low, 4 high per bit; optional read at cycle rc
  task automatic sendByte(bit [7:0] b, int nBits, int rc);
    for (int c = 0; c < 8 * nBits; c++) begin
      @(negedge clk);
      if (c % 8 == 0) sdIn = b[7 - c / 8];
      sclkIn = (c % 8) >= 4;
      regAddr = 2'd3;
      regRdEn = (c == rc);
      if (c == rc) begin
        #1;
        check("R7 read during frame", int'(regRdData), expReg(3));
      end
    end
    @(negedge clk);
    sclkIn = 0; regRdEn = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int rises, falls, hi, hiLen;
    bit prev, seen;
    bit [7:0] mb;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rdChk(0, 0, "R1"); rdChk(1, 0, "R1"); rdChk(2, 0, "R1");
    check("R1 irq", int'(irq), 0);
    check("R1 sclkOut", int'(sclkOut), 0);
    selN = 0;
    // R2 nothing captured before enable and arming
    sendByte(8'h5A, 8, -1);
    rdChk(2, 0, "R2 not enabled");
    wrReg(0, 1);
    sendByte(8'h5A, 8, -1);
    rdChk(2, 0, "R2 enabled but not armed");
    rdChk(3, 0, "R2 dummy read");
    wrReg(0, 3);
    // R3 R4 R5 basic frame
    sendByte(8'hA5, 8, -1);
    rdChk(2, 1, "R4 full set");
    check("R5 irq high", int'(irq), 1);
    rdChk(3, 8'hA5, "R3 data msb first");
    rdChk(2, 0, "R6 read clears full");
    // R3 select high drops partial frame
    sendByte(8'hFF, 3, -1);
    @(negedge clk); selN = 1;
    repeat (6) @(negedge clk); selN = 0;
    repeat (4) @(negedge clk);
    sendByte(8'h3C, 8, -1);
    rdChk(3, 8'h3C, "R3 partial discarded");
    selN = 1;
    sendByte(8'h5A, 8, -1);
    rdChk(2, 0, "R3 select high ignored");
    selN = 0;
    repeat (4) @(negedge clk);
    // R8 silent drop
    sendByte(8'h11, 8, -1);
    sendByte(8'h22, 8, -1);
    rdChk(2, 1, "R8 no flags");
    rdChk(3, 8'h11, "R8 data kept");
    // R7 read mid-frame
    sendByte(8'h33, 8, -1);
    sendByte(8'h44, 8, 20);
    rdChk(2, 2, "R7 conflict set");
    rdChk(3, 8'h33, "R7 frame not stored");
    // R9 sticky conflict
    sendByte(8'h55, 8, -1);
    rdChk(2, 2, "R9 no store while conflict");
    wrReg(2, 2);
    rdChk(2, 2, "R9 bit1 one keeps flag");
    wrReg(2, 0);
    rdChk(2, 0, "R9 cleared");
    // R7 read on the last bit
    sendByte(8'h66, 8, -1);
    sendByte(8'h77, 8, 62);
    rdChk(2, 2, "R7 last-bit read");
    wrReg(2, 0);
    // R6 store beats clear in the same cycle
    sendByte(8'h88, 8, 62);
    rdChk(2, 1, "R6 store wins");
    rdChk(3, 8'h88, "R6 data");
    // R7 read on the first bit
    sendByte(8'h99, 8, -1);
    sendByte(8'hAA, 8, 6);
    rdChk(2, 2, "R7 first-bit read");
    rdChk(3, 8'h99, "R7 data");
    wrReg(2, 0);
    // R11 abort keeps data and flags, disarms
    sendByte(8'hB4, 8, -1);
    sendByte(8'hFF, 4, -1);
    wrReg(0, 2);
    rdChk(2, 1, "R11 flags kept");
    rdChk(3, 8'hB4, "R11 data kept");
    wrReg(0, 3);
    sendByte(8'h0F, 8, -1);
    rdChk(2, 0, "R11 disarmed");
    sendByte(8'hFF, 4, -1);
    wrReg(0, 2);
    wrReg(0, 3);
    rdChk(3, 8'hB4, "R11 rearm");
    sendByte(8'hC3, 8, -1);
    rdChk(3, 8'hC3, "R11 count reset");
    // R10 master mode
    cmpOn = 0;
    selN = 1;
    mb = 8'h6D;
    sdIn = mb[7];
    wrReg(1, 3);
    rdChk(1, 3, "R10 divider");
    wrReg(0, 5);
    rdChk(3, 8'hC3, "R10 arm");
    rises = 0; falls = 0; hi = 0; hiLen = 0; prev = 0;
    for (int c = 0; c < 120; c++) begin
      @(negedge clk);
      if (sclkOut && !prev) rises++;
      if (sclkOut) hi++;
      if (!sclkOut && prev) begin
        falls++;
        if (hiLen == 0) hiLen = hi;
        hi = 0;
        if (falls < 8) sdIn = mb[7 - falls];
      end
      prev = sclkOut;
    end
    check("R10 eight rising edges", rises, 8);
    check("R10 high time", hiLen, 4);
    check("R10 idle low", int'(sclkOut), 0);
    rdChk(2, 1, "R10 full");
    rdChk(3, int'(mb), "R10 master data");
    seen = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (sclkOut) seen = 1;
    end
    check("R10 restart after read", int'(seen), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule